// File: doc/BRIEF.md
# Hashed Page Table Walker

This block looks up a page translation in a hashed page table held in memory. A request carries a 32-bit effective address, the 24-bit segment identifier that the upper four address bits selected, an access-type flag (instruction or data), and a configuration word. The configuration word holds the table origin in bits 31:16 and a 9-bit table size mask in bits 8:0. From these inputs the walker forms two hash values and the matching group addresses. It then searches the primary group one entry at a time through a 32-bit read port that uses a ready handshake. It searches the secondary group only if the primary group has no match.

When the walk ends, the walker raises `done` for one cycle. The result registers then show hit or miss, the lower word of the matching entry, and whether the secondary hash found it. Both group addresses are kept in visible registers. The compare word is kept in a register chosen by the access type. Protection checks and fault delivery belong to the logic that uses this block.

Top module: `hpt_walker`

## Requirements
- R1: The primary hash is the segment identifier bits 18:0 XOR the effective address bits 27:12, zero-extended to 19 bits. The primary group address is built from this hash as R3 describes.
- R2: The secondary hash is the primary hash XOR 0x7FFFF. The secondary group address is built from it in the same way.
- R3: A group address is formed as follows. Bits 31:25 are origin bits 31:25. Bits 24:16 are origin bits 24:16 ORed with (hash bits 18:10 AND mask). Bits 15:6 are hash bits 9:0. Bits 5:0 are zero.
- R4: Entries are read in order 0 to 7. The upper word of entry i is read at group+8·i. The lower word is read at group+8·i+4, and only right after that entry's upper word matched. The read port returns a word with the byte at the lowest address in bits 31:24.
- R5: The compare word has bit 31 set to 1 (valid), bits 30:7 equal to the segment identifier, bit 6 equal to the hash-select bit, and bits 5:0 equal to effective address bits 27:22. A match requires all 32 bits to be equal.
- R6: The secondary group is searched with hash-select set to 1, and only after all 8 primary entries have failed. A hit found there sets `hit_secondary`; a primary hit clears it.
- R7: If all 16 upper words fail to match, the walk ends with `done`, `hit`=0, `hit_secondary`=0 and `lower_word`=0. Exactly 16 reads take place.
- R8: Each accepted walk writes both group addresses into `grp_pri`/`grp_sec`. It also writes the primary compare word into `cmp_instr` when `req_instr`=1, or into `cmp_data` otherwise, and the other register keeps its value.
- R9: A request is accepted only while `busy`=0. `busy` rises the cycle after acceptance and stays high until the cycle in which `done` is 1. A request made while busy is ignored.
- R10: `mem_rd_en` is high only during a walk. `mem_rd_addr` is held steady until `mem_rd_ready` is seen, and the word is taken in the cycle where both are high.
- R11: After reset, `busy`, `done`, `hit`, `hit_secondary`, `mem_rd_en` and every result and latch register are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a walk (taken only when idle) |
| req_instr | input | 1 | 1 = instruction access, 0 = data access |
| req_ea | input | 32 | Effective address |
| req_seg | input | 24 | Segment identifier |
| req_cfg | input | 32 | Table origin in bits 31:16, size mask in bits 8:0 |
| mem_rd_en | output | 1 | Read request |
| mem_rd_addr | output | 32 | Read byte address |
| mem_rd_ready | input | 1 | Read data valid / request taken |
| mem_rd_data | input | 32 | Read word |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| hit | output | 1 | Last walk found a match |
| hit_secondary | output | 1 | Match came from the secondary group |
| lower_word | output | 32 | Lower word of the matching entry |
| grp_pri | output | 32 | Latched primary group address |
| grp_sec | output | 32 | Latched secondary group address |
| cmp_instr | output | 32 | Compare word of last instruction walk |
| cmp_data | output | 32 | Compare word of last data walk |

## Verification
The address sweep changes the segment identifier, the effective address, the origin and the mask (zero, all ones, and two alternating patterns) on an empty table. Each run shows whether the XOR, the mask, and the OR into the origin bits are wired correctly, and the full 16-read miss order must appear. Planted entries then separate the outcomes: a primary hit at a middle entry (scan order, and the lower word read only after the match), a secondary hit at entries 0 and 7 (the switch to the second group and the hash-select bit), and a primary-group entry that carries the secondary flag, which must not match. A second request issued while a walk is running, and walks that alternate between instruction and data, show that busy requests are ignored and that the compare word goes to the register chosen by the access type.

// File: rtl/hpt_pkg.sv
package hpt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_UPPER = 2'd1,
    ST_LOWER = 2'd2
  } walk_st_e;

  localparam int HSEL_BIT = 6;

  function automatic logic [31:0] make_cmp(input logic [23:0] seg,
                                           input logic        hsel,
                                           input logic [5:0]  api);
    return {1'b1, seg, hsel, api};
  endfunction
endpackage

// File: rtl/hpt_hash.sv
module hpt_hash #(
  parameter int HASH_W = 19,
  parameter int SEG_W  = 24,
  parameter int PG_LSB = 12,
  parameter int PG_W   = 16
) (
  input  logic [SEG_W-1:0]  seg,
  input  logic [31:0]       ea,
  output logic [HASH_W-1:0] hash_pri,
  output logic [HASH_W-1:0] hash_sec
);
  localparam int PAD_W = HASH_W - PG_W;

  always_comb begin
    hash_pri = seg[HASH_W-1:0] ^ {{PAD_W{1'b0}}, ea[PG_LSB +: PG_W]};
    hash_sec = hash_pri ^ {HASH_W{1'b1}};
  end
endmodule

// File: rtl/hpt_group_addr.sv
module hpt_group_addr #(
  parameter int HASH_W = 19,
  parameter int MASK_W = 9,
  parameter int OFS_W  = 6
) (
  input  logic [31:0]       origin,
  input  logic [MASK_W-1:0] mask,
  input  logic [HASH_W-1:0] hash,
  output logic [31:0]       grp
);
  localparam int LO_W    = HASH_W - MASK_W;
  localparam int MID_LSB = OFS_W + LO_W;
  localparam int TOP_LSB = MID_LSB + MASK_W;
  localparam int TOP_W   = 32 - TOP_LSB;

  always_comb begin
    grp = {origin[31 -: TOP_W],
           origin[MID_LSB +: MASK_W] | (hash[LO_W +: MASK_W] & mask),
           hash[LO_W-1:0],
           {OFS_W{1'b0}}};
  end
endmodule

// File: rtl/hpt_walker.sv
module hpt_walker #(
  parameter int ENTRIES     = 8,
  parameter int ENTRY_BYTES = 8,
  parameter int HASH_W      = 19,
  parameter int MASK_W      = 9,
  parameter int SEG_W       = 24
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  input  logic        req_instr,
  input  logic [31:0] req_ea,
  input  logic [23:0] req_seg,
  input  logic [31:0] req_cfg,
  output logic        mem_rd_en,
  output logic [31:0] mem_rd_addr,
  input  logic        mem_rd_ready,
  input  logic [31:0] mem_rd_data,
  output logic        busy,
  output logic        done,
  output logic        hit,
  output logic        hit_secondary,
  output logic [31:0] lower_word,
  output logic [31:0] grp_pri,
  output logic [31:0] grp_sec,
  output logic [31:0] cmp_instr,
  output logic [31:0] cmp_data
);
  import hpt_pkg::*;

  localparam int IDX_W    = $clog2(ENTRIES);
  localparam int OFS_W    = $clog2(ENTRIES * ENTRY_BYTES);
  localparam int ESH      = $clog2(ENTRY_BYTES);
  localparam int LOW_OFS  = ENTRY_BYTES / 2;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  logic [HASH_W-1:0] h_pri, h_sec;
  logic [31:0]       ga_pri, ga_sec, cmp_new;

  hpt_hash #(.HASH_W(HASH_W), .SEG_W(SEG_W)) u_hash (
    .seg(req_seg), .ea(req_ea), .hash_pri(h_pri), .hash_sec(h_sec)
  );

  hpt_group_addr #(.HASH_W(HASH_W), .MASK_W(MASK_W), .OFS_W(OFS_W)) u_ga_pri (
    .origin(req_cfg), .mask(req_cfg[MASK_W-1:0]), .hash(h_pri), .grp(ga_pri)
  );

  hpt_group_addr #(.HASH_W(HASH_W), .MASK_W(MASK_W), .OFS_W(OFS_W)) u_ga_sec (
    .origin(req_cfg), .mask(req_cfg[MASK_W-1:0]), .hash(h_sec), .grp(ga_sec)
  );

  assign cmp_new = make_cmp(req_seg, 1'b0, req_ea[27:22]);

  walk_st_e         st_q;
  logic [IDX_W-1:0] idx_q;
  logic             use_sec_q;
  logic [31:0]      cmp_cur_q;
  logic             accept;
  logic             last_entry;
  logic [31:0]      grp_cur;

  assign accept     = (st_q == ST_IDLE) && req_valid;
  assign last_entry = (idx_q == LAST_IDX);
  assign grp_cur    = use_sec_q ? grp_sec : grp_pri;

  always_comb begin
    mem_rd_en   = (st_q != ST_IDLE);
    mem_rd_addr = grp_cur + ({{(32-IDX_W){1'b0}}, idx_q} << ESH)
                + ((st_q == ST_LOWER) ? 32'(LOW_OFS) : 32'd0);
    busy        = (st_q != ST_IDLE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q          <= ST_IDLE;
      idx_q         <= '0;
      use_sec_q     <= 1'b0;
      cmp_cur_q     <= '0;
      done          <= 1'b0;
      hit           <= 1'b0;
      hit_secondary <= 1'b0;
      lower_word    <= '0;
      grp_pri       <= '0;
      grp_sec       <= '0;
      cmp_instr     <= '0;
      cmp_data      <= '0;
    end else begin
      done <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (accept) begin
            st_q      <= ST_UPPER;
            idx_q     <= '0;
            use_sec_q <= 1'b0;
            cmp_cur_q <= cmp_new;
            grp_pri   <= ga_pri;
            grp_sec   <= ga_sec;
            if (req_instr) cmp_instr <= cmp_new;
            else           cmp_data  <= cmp_new;
          end
        end
        ST_UPPER: begin
          if (mem_rd_ready) begin
            if (mem_rd_data == cmp_cur_q) begin
              st_q <= ST_LOWER;
            end else if (!last_entry) begin
              idx_q <= idx_q + 1'b1;
            end else if (!use_sec_q) begin
              use_sec_q           <= 1'b1;
              idx_q               <= '0;
              cmp_cur_q[HSEL_BIT] <= 1'b1;
            end else begin
              st_q          <= ST_IDLE;
              done          <= 1'b1;
              hit           <= 1'b0;
              hit_secondary <= 1'b0;
              lower_word    <= '0;
            end
          end
        end
        ST_LOWER: begin
          if (mem_rd_ready) begin
            st_q          <= ST_IDLE;
            done          <= 1'b1;
            hit           <= 1'b1;
            hit_secondary <= use_sec_q;
            lower_word    <= mem_rd_data;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hpt_walker_chk.sv
module hpt_walker_chk (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic        mem_rd_en,
  input logic [31:0] mem_rd_addr,
  input logic        mem_rd_ready,
  input logic        busy,
  input logic        done,
  input logic        hit,
  input logic        hit_secondary,
  input logic [31:0] grp_pri,
  input logic [31:0] grp_sec
);
  AST_ACCEPT_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!busy && req_valid) |=> busy); // R9

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R9

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9

  AST_READ_IN_WALK: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |-> busy); // R10

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_en && !mem_rd_ready) |=> (mem_rd_en && $stable(mem_rd_addr))); // R10

  AST_ADDR_IN_GROUP: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |-> (mem_rd_addr[31:6] == grp_pri[31:6] ||
                   mem_rd_addr[31:6] == grp_sec[31:6])); // R4

  AST_SEC_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
    hit_secondary |-> hit); // R6
endmodule

bind hpt_walker hpt_walker_chk u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .mem_rd_en(mem_rd_en),
  .mem_rd_addr(mem_rd_addr), .mem_rd_ready(mem_rd_ready), .busy(busy),
  .done(done), .hit(hit), .hit_secondary(hit_secondary),
  .grp_pri(grp_pri), .grp_sec(grp_sec)
);

// File: tb/sim_hpt_walker.sv
`timescale 1ns/1ps
module sim_hpt_walker;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_instr = 1'b0;
  logic [31:0] req_ea = '0, req_cfg = '0;
  logic [23:0] req_seg = '0;
  logic        mem_rd_en;
  logic [31:0] mem_rd_addr;
  logic        mem_rd_ready;
  logic [31:0] mem_rd_data;
  logic        busy, done, hit, hit_secondary;
  logic [31:0] lower_word, grp_pri, grp_sec, cmp_instr, cmp_data;

  always #2 clk = ~clk;

  hpt_walker u0 (.*);

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [31:0] pa [4];
  logic [31:0] pv [4];
  int np = 0;
  logic [31:0] rlog [32];
  int nlog = 0;
  int wcnt = 0, lat = 0;

  function automatic logic [31:0] lookup(input logic [31:0] a);
    for (int k = 0; k < np; k++) if (pa[k] == a) return pv[k];
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      mem_rd_ready <= 1'b0; mem_rd_data <= '0; wcnt <= 0;
    end else if (mem_rd_en && !mem_rd_ready) begin
      if (wcnt >= lat) begin
        mem_rd_ready <= 1'b1;
        mem_rd_data  <= lookup(mem_rd_addr);
        wcnt <= 0;
        lat  <= (lat + 1) % 3;
      end else wcnt <= wcnt + 1;
    end else begin
      if (mem_rd_en && mem_rd_ready && nlog < 32) begin
        rlog[nlog] = mem_rd_addr;
        nlog = nlog + 1;
      end
      mem_rd_ready <= 1'b0;
    end
  end

  function automatic logic [31:0] eg(input logic [31:0] ea, input logic [23:0] seg,
                                     input logic [31:0] cfg, input bit sec);
    logic [18:0] h;
    h = seg[18:0] ^ {3'b0, ea[27:12]};
    if (sec) h = h ^ 19'h7FFFF;
    return {cfg[31:25], cfg[24:16] | (h[18:10] & cfg[8:0]), h[9:0], 6'b0};
  endfunction

  function automatic logic [31:0] ec(input logic [31:0] ea, input logic [23:0] seg,
                                     input bit sec);
    return {1'b1, seg, sec, ea[27:22]};
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic start_walk(input logic [31:0] ea, input logic [23:0] seg,
                            input logic [31:0] cfg, input bit ins);
    @(negedge clk);
    nlog = 0;
    req_ea = ea; req_seg = seg; req_cfg = cfg; req_instr = ins; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done();
    int t = 0;
    while (!done && t < 1000) begin
      @(negedge clk);
      t++;
    end
    if (!done) begin
      chk(0, "R9 watchdog walk", 0, 1);
      finish_up();
    end
  endtask

  task automatic check_miss_log(input logic [31:0] gp, input logic [31:0] gs,
                                input string rq);
    bit ok = (nlog == 16);
    for (int i = 0; i < 8 && ok; i++) begin
      if (rlog[i] != gp + 32'(8 * i)) ok = 0;
      if (rlog[8 + i] != gs + 32'(8 * i)) ok = 0;
    end
    chk(ok, rq, 32'(nlog), 32'd16);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (cyc > 150000) begin
        chk(0, "watchdog", 32'(cyc), 0);
        finish_up();
      end
    end
  end

  initial begin
    logic [31:0] ea, cfg, gp, gs, ci_exp, cd_exp;
    logic [23:0] seg;
    logic [8:0]  masks [4];
    masks[0] = 9'h000; masks[1] = 9'h1FF; masks[2] = 9'h0AA; masks[3] = 9'h155;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk({busy, done, hit, hit_secondary, mem_rd_en} == 5'b0, "R11 flags", 
        {27'b0, busy, done, hit, hit_secondary, mem_rd_en}, 0);
    chk((lower_word | grp_pri | grp_sec | cmp_instr | cmp_data) == 0, "R11 regs",
        lower_word | grp_pri | grp_sec | cmp_instr | cmp_data, 0);
    ci_exp = 0; cd_exp = 0;

    // R1 R2 R3 R5 R7 R8 sweep over an empty table
    for (int i = 0; i < 12; i++) begin
      ea  = (32'h1234_5000 * 32'(i + 1)) ^ (32'(i) << 22) ^ 32'h8000_0000;
      seg = 24'hA5_0000 ^ (24'h01_3579 * 24'(i + 3));
      cfg = ((32'h0A40_0000 + 32'h0013_0000 * 32'(i)) & 32'hFFFF_0000) | {23'b0, masks[i % 4]};
      start_walk(ea, seg, cfg, i[0]);
      wait_done();
      gp = eg(ea, seg, cfg, 0);
      gs = eg(ea, seg, cfg, 1);
      if (i[0]) ci_exp = ec(ea, seg, 0); else cd_exp = ec(ea, seg, 0);
      chk(grp_pri == gp, "R1 R3 primary group", grp_pri, gp);
      chk(grp_sec == gs, "R2 R3 secondary group", grp_sec, gs);
      chk(cmp_instr == ci_exp, "R5 R8 instr compare", cmp_instr, ci_exp);
      chk(cmp_data == cd_exp, "R5 R8 data compare", cmp_data, cd_exp);
      chk(!hit && !hit_secondary && lower_word == 0, "R7 miss result",
          {hit, hit_secondary, lower_word[29:0]}, 0);
      check_miss_log(gp, gs, "R7 R4 sixteen reads in order");
      @(negedge clk);
      chk(!busy && !done, "R9 idle after done", {30'b0, busy, done}, 0);
    end

    // R4 R6 primary hit at entry 3 with a near-miss at entry 1
    ea = 32'h3C81_7000; seg = 24'h5A_1234; cfg = 32'h0122_01F0;
    gp = eg(ea, seg, cfg, 0);
    np = 2;
    pa[0] = gp + 8;  pv[0] = ec(ea, seg, 0) ^ 32'h0000_0100;
    pa[1] = gp + 24; pv[1] = ec(ea, seg, 0);
    pa[2] = gp + 28; pv[2] = 32'hDEAD_B00F;
    np = 3;
    start_walk(ea, seg, cfg, 0);
    wait_done();
    chk(hit && !hit_secondary, "R6 primary hit flags", {30'b0, hit, hit_secondary}, 2);
    chk(lower_word == 32'hDEAD_B00F, "R4 lower word", lower_word, 32'hDEAD_B00F);
    chk(nlog == 5 && rlog[0] == gp && rlog[3] == gp + 24 && rlog[4] == gp + 28,
        "R4 scan then lower read", 32'(nlog), 5);

    // R6 secondary hit at entry 0
    gs = eg(ea, seg, cfg, 1);
    np = 2;
    pa[0] = gs;     pv[0] = ec(ea, seg, 1);
    pa[1] = gs + 4; pv[1] = 32'h1357_9BDF;
    start_walk(ea, seg, cfg, 1);
    wait_done();
    chk(hit && hit_secondary, "R6 secondary hit flags", {30'b0, hit, hit_secondary}, 3);
    chk(lower_word == 32'h1357_9BDF, "R6 secondary lower", lower_word, 32'h1357_9BDF);
    chk(nlog == 10 && rlog[7] == gp + 56 && rlog[8] == gs && rlog[9] == gs + 4,
        "R6 secondary after primary", 32'(nlog), 10);

    // R6 secondary hit at entry 7
    pa[0] = gs + 56; pv[0] = ec(ea, seg, 1);
    pa[1] = gs + 60; pv[1] = 32'h2468_ACE0;
    start_walk(ea, seg, cfg, 0);
    wait_done();
    chk(hit && hit_secondary && lower_word == 32'h2468_ACE0, "R6 last secondary entry",
        lower_word, 32'h2468_ACE0);

    // R5 R6 primary group entry carrying the select bit must not match
    np = 1;
    pa[0] = gp + 16; pv[0] = ec(ea, seg, 1);
    start_walk(ea, seg, cfg, 0);
    wait_done();
    chk(!hit, "R5 select bit in primary ignored", {31'b0, hit}, 0);
    check_miss_log(gp, gs, "R7 miss reads");

    // R9 request during a walk ignored
    np = 0;
    start_walk(ea, seg, cfg, 0);
    chk(busy, "R9 busy after accept", {31'b0, busy}, 1);
    @(negedge clk);
    req_ea = 32'hFFFF_F000; req_seg = 24'h00_0001; req_instr = 1'b1; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    ci_exp = cmp_instr;
    wait_done();
    chk(grp_pri == gp, "R9 busy request ignored group", grp_pri, gp);
    chk(cmp_instr == ci_exp, "R9 busy request ignored compare", cmp_instr, ci_exp);
    check_miss_log(gp, gs, "R9 single walk reads");
    @(negedge clk);
    chk(!busy && !mem_rd_en, "R10 no read when idle", {30'b0, busy, mem_rd_en}, 0);

    finish_up();
  end
endmodule